// File: doc/BRIEF.md
# Synchronous SCSI Transfer Rate Generator

This block derives the timing for synchronous SCSI data phases from the core clock. Two independent dividers turn the core clock into single-cycle clock enables: one paces the synchronous transfer logic and one paces the asynchronous control logic. Each divider is programmed by its own 3-bit factor field in a control word. A send timer counts synchronous enables and produces a square-ish send strobe. The send period is set by a transfer period field. A receive tick marks every fourth synchronous enable, which is the fastest rate at which incoming data can be sampled.

A configuration-error flag reports settings that cannot work. These are a reserved divider code, fast mode requested while the clock doubler is off, or a synchronous divider output above the allowed ceiling. Changes to the divider or period fields are taken up only on the boundary of the current divided cycle or send period. The enables and strobes therefore never shorten mid-period. A synchronous clear input restarts every counter.

Top module: `srg_rate_gen`

## Requirements
- R1: While rst_ni is low, and in the cycle after a cycle with sync_clr_i high, sync_ce_o, async_ce_o, send_stb_o and rx_tick_o are all low.
- R2: Synchronous factor ctrl_i[6:4] sets the spacing of sync_ce_o pulses in core cycles: codes 0 and 1 give 1, code 2 gives gaps alternating 1 and 2, code 3 gives 2, code 4 gives 3 and code 5 gives 4.
- R3: Asynchronous factor ctrl_i[2:0] sets the async_ce_o spacing with the same code table as R2, independently of the synchronous factor.
- R4: Codes 6 and 7 in either factor field are reserved: the affected enable stays low and cfg_err_o is high.
- R5: cfg_err_o is high when fast mode ctrl_i[7] is set while dbl_en_i is low.
- R6: cfg_err_o is high when the core clock rate (IN_CLK_MHZ, doubled when dbl_en_i is high) divided by the synchronous factor exceeds MAX_SYNC_MHZ.
- R7: While xfer_act_i is high, send_stb_o repeats every (P + 4) synchronous enables, where P is xfer_i[7:5], and stays high for floor((P + 4) / 2) of them.
- R8: send_stb_o is low whenever xfer_act_i is low.
- R9: rx_tick_o pulses together with every fourth sync_ce_o and never in two consecutive cycles.
- R10: A new factor code takes effect only after the current divided cycle ends, and a new period only after the current send period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_clr_i | input | 1 | Synchronous clear of all counters |
| dbl_en_i | input | 1 | Internal clock doubler is active |
| xfer_act_i | input | 1 | Synchronous data phase in progress |
| ctrl_i | input | 8 | [7] fast mode, [6:4] synchronous factor, [2:0] asynchronous factor |
| xfer_i | input | 8 | [7:5] transfer period field |
| sync_ce_o | output | 1 | Enable for synchronous transfer logic |
| async_ce_o | output | 1 | Enable for asynchronous control logic |
| send_stb_o | output | 1 | Synchronous send strobe |
| rx_tick_o | output | 1 | Receive sampling rate tick |
| cfg_err_o | output | 1 | Illegal configuration |

## Verification
Assertions check on every cycle that the send strobe only changes on a synchronous enable and that the period counter stays inside the programmed period. They also check that multi-cycle divider codes never give back-to-back enables, and that receive ticks coincide with enables and are never adjacent. The exact enable spacing per code, the strobe high time and period, and the error flag conditions are shown only by the bench scenarios. So are the clear behaviour and the deferred take-up of new codes at a boundary.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int unsigned FACT_W = 3;
  localparam int unsigned DCNT_W = 2;

  typedef enum logic [FACT_W-1:0] {
    FAC_DIV1A = 3'd0,
    FAC_DIV1B = 3'd1,
    FAC_DIV1P5 = 3'd2,
    FAC_DIV2 = 3'd3,
    FAC_DIV3 = 3'd4,
    FAC_DIV4 = 3'd5,
    FAC_RSV6 = 3'd6,
    FAC_RSV7 = 3'd7
  } fac_e;

  function automatic logic fac_rsv(input logic [FACT_W-1:0] s);
    return s[2] & s[1];
  endfunction

  // last count value of a divided cycle; ph picks the long half of 1.5
  function automatic logic [DCNT_W-1:0] fac_term(input logic [FACT_W-1:0] s, input logic ph);
    case (fac_e'(s))
      FAC_DIV1P5: return ph ? 2'd1 : 2'd0;
      FAC_DIV2:   return 2'd1;
      FAC_DIV3:   return 2'd2;
      FAC_DIV4:   return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction

  // division ratio in half steps
  function automatic int unsigned fac_halves(input logic [FACT_W-1:0] s);
    case (fac_e'(s))
      FAC_DIV1P5: return 3;
      FAC_DIV2:   return 4;
      FAC_DIV3:   return 6;
      FAC_DIV4:   return 8;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/srg_clk_div.sv
module srg_clk_div
  import srg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [FACT_W-1:0] sel_i,
  output logic              ce_o
);
  logic [FACT_W-1:0] cur_q;
  logic [DCNT_W-1:0] cnt_q;
  logic              ph_q;
  logic              live_q;

  assign ce_o = live_q & ~fac_rsv(cur_q) & (cnt_q == fac_term(cur_q, ph_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      live_q <= 1'b0;
    end else if (clr_i) begin
      cur_q  <= sel_i;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      live_q <= 1'b0;
    end else if (!live_q) begin
      live_q <= 1'b1;
      cur_q  <= sel_i;
    end else if (fac_rsv(cur_q)) begin
      cur_q <= sel_i;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (ce_o) begin
      cnt_q <= '0;
      // new code only on a boundary
      if (sel_i != cur_q) begin
        cur_q <= sel_i;
        ph_q  <= 1'b0;
      end else begin
        ph_q <= ~ph_q;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_no_back2back_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_q inside {3'd3, 3'd4, 3'd5}) && $past(ce_o)) |-> !ce_o);
endmodule

// File: rtl/srg_send_timer.sv
module srg_send_timer #(
  parameter int unsigned TP_W        = 3,
  parameter int unsigned PERIOD_BASE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ce_i,
  input  logic            act_i,
  input  logic [TP_W-1:0] tp_i,
  output logic            stb_o
);
  localparam int unsigned PER_MAX = (1 << TP_W) - 1 + PERIOD_BASE;
  localparam int unsigned PC_W    = $clog2(PER_MAX + 1);

  logic [TP_W-1:0] tp_q;
  logic [PC_W-1:0] pcnt_q, per_m1, half;
  logic            run_q;

  assign per_m1 = PC_W'(tp_q) + PC_W'(PERIOD_BASE - 1);
  assign half   = (PC_W'(tp_q) + PC_W'(PERIOD_BASE)) >> 1;
  assign stb_o  = act_i & run_q & (pcnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q   <= '0;
      pcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (clr_i || !act_i) begin
      tp_q   <= tp_i;
      pcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (ce_i) begin
      if (!run_q) begin
        run_q  <= 1'b1;
        pcnt_q <= '0;
      end else if (pcnt_q == per_m1) begin
        pcnt_q <= '0;
        tp_q   <= tp_i;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  p_stb_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && $past(act_i) && !$past(ce_i) && !$past(clr_i)) |-> $stable(stb_o));

  p_pcnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= per_m1);
endmodule

// File: rtl/srg_rx_tick.sv
module srg_rx_tick #(
  parameter int unsigned RX_RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ce_i,
  output logic tick_o
);
  localparam int unsigned RC_W = $clog2(RX_RATIO);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RX_RATIO - 1);

  logic [RC_W-1:0] cnt_q;

  assign tick_o = ce_i & (cnt_q == RC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (ce_i)    cnt_q <= cnt_q + 1'b1;
  end

  p_rx_on_ce_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ce_i);

  p_rx_spaced_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/srg_rate_gen.sv
module srg_rate_gen
  import srg_pkg::*;
#(
  parameter int unsigned IN_CLK_MHZ   = 40,
  parameter int unsigned MAX_SYNC_MHZ = 80,
  parameter int unsigned TP_W         = 3,
  parameter int unsigned PERIOD_BASE  = 4,
  parameter int unsigned RX_RATIO     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_clr_i,
  input  logic       dbl_en_i,
  input  logic       xfer_act_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] xfer_i,
  output logic       sync_ce_o,
  output logic       async_ce_o,
  output logic       send_stb_o,
  output logic       rx_tick_o,
  output logic       cfg_err_o
);
  localparam int unsigned NDIV = 2;

  logic [NDIV-1:0][FACT_W-1:0] fac;
  logic [NDIV-1:0]             ce;
  logic                        fast;
  logic [TP_W-1:0]             tp;
  int unsigned                 eff_mhz;
  logic                        over_rate;

  assign fac[0] = ctrl_i[6:4];
  assign fac[1] = ctrl_i[2:0];
  assign fast   = ctrl_i[7];
  assign tp     = xfer_i[7 -: TP_W];

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    srg_clk_div u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sync_clr_i),
      .sel_i  (fac[g]),
      .ce_o   (ce[g])
    );
  end

  assign sync_ce_o  = ce[0];
  assign async_ce_o = ce[1];

  srg_send_timer #(
    .TP_W        (TP_W),
    .PERIOD_BASE (PERIOD_BASE)
  ) u_send (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_clr_i),
    .ce_i   (ce[0]),
    .act_i  (xfer_act_i),
    .tp_i   (tp),
    .stb_o  (send_stb_o)
  );

  srg_rx_tick #(
    .RX_RATIO (RX_RATIO)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_clr_i),
    .ce_i   (ce[0]),
    .tick_o (rx_tick_o)
  );

  // rate ceiling compared in half-step units to avoid fractions
  always_comb begin
    eff_mhz   = dbl_en_i ? 2 * IN_CLK_MHZ : IN_CLK_MHZ;
    over_rate = !fac_rsv(fac[0]) && (eff_mhz * 2 > MAX_SYNC_MHZ * fac_halves(fac[0]));
  end

  assign cfg_err_o = fac_rsv(fac[0]) | fac_rsv(fac[1]) | (fast & ~dbl_en_i) | over_rate;
endmodule

// File: tb/srg_rate_gen_tb_top.sv
`timescale 1ns/1ps
module srg_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, dbl = 1'b0, act = 1'b0;
  logic [7:0] ctrl = '0, xfer = '0;
  logic sce, ace, stb, rxt, err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  srg_rate_gen #(.IN_CLK_MHZ(50), .MAX_SYNC_MHZ(80)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_clr_i(clr), .dbl_en_i(dbl),
    .xfer_act_i(act), .ctrl_i(ctrl), .xfer_i(xfer),
    .sync_ce_o(sce), .async_ce_o(ace), .send_stb_o(stb),
    .rx_tick_o(rxt), .cfg_err_o(err)
  );

  task automatic chk(input string req, input string what, input int a, input int e);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic cfg(input bit f, input int sf, input int af, input int tp);
    ctrl = {f, 3'(sf), 1'b0, 3'(af)};
    xfer = {3'(tp), 5'b0};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_sce(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sce && n < 200);
  endtask

  task automatic next_ace(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ace && n < 200);
  endtask

  task automatic from_rise(output int hi, output int per);
    int lo = 1;
    hi = 1;
    @(negedge clk);
    while (stb && hi < 500) begin hi++; @(negedge clk); end
    @(negedge clk);
    while (!stb && lo < 500) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic meas_stb(output int hi, output int per);
    int g = 0;
    do begin @(negedge clk); g++; end while (stb && g < 500);
    do begin @(negedge clk); g++; end while (!stb && g < 1000);
    from_rise(hi, per);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1", "sce in reset", sce, 0);
    chk("R1", "ace in reset", ace, 0);
    chk("R1", "stb in reset", stb, 0);
    chk("R1", "rx in reset", rxt, 0);
    rst_n = 1'b1;
    cfg(0, 0, 0, 0); act = 1'b1;
    idle(10);
    clr = 1'b1;
    @(negedge clk);
    chk("R1", "sce after clear", sce, 0);
    chk("R1", "ace after clear", ace, 0);
    chk("R1", "stb after clear", stb, 0);
    chk("R1", "rx after clear", rxt, 0);
    clr = 1'b0; act = 1'b0;
  endtask

  task automatic t_sync_div();
    int g1, g2;
    int exp_gap[6] = '{1, 1, 0, 2, 3, 4};
    for (int e = 0; e < 6; e++) begin
      cfg(0, e, 0, 0);
      idle(12);
      next_sce(g1); next_sce(g1); next_sce(g2);
      if (e == 2) begin
        chk("R2", "div1.5 gap sum", g1 + g2, 3);
        chk("R2", "div1.5 gaps differ", int'(g1 != g2), 1);
      end else begin
        chk("R2", $sformatf("sync gap code %0d", e), g1, exp_gap[e]);
        chk("R2", $sformatf("sync gap2 code %0d", e), g2, exp_gap[e]);
      end
    end
  endtask

  task automatic t_async_div();
    int g;
    int exp_gap[6] = '{1, 1, 0, 2, 3, 4};
    for (int e = 0; e < 6; e++) begin
      if (e == 2) continue;
      cfg(0, 5, e, 0);
      idle(12);
      next_ace(g); next_ace(g);
      chk("R3", $sformatf("async gap code %0d", e), g, exp_gap[e]);
      next_sce(g); next_sce(g);
      chk("R3", "sync gap unaffected", g, 4);
    end
  endtask

  task automatic t_reserved();
    int cnt = 0;
    cfg(0, 6, 0, 0);
    idle(8);
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(sce); end
    chk("R4", "sync ce with code 6", cnt, 0);
    chk("R4", "err with sync code 6", err, 1);
    cfg(0, 0, 7, 0);
    idle(8); cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(ace); end
    chk("R4", "async ce with code 7", cnt, 0);
    chk("R4", "err with async code 7", err, 1);
    cfg(0, 3, 3, 0);
    idle(8);
    next_sce(cnt); next_sce(cnt);
    chk("R4", "recovery from reserved", cnt, 2);
    chk("R4", "err cleared", err, 0);
  endtask

  task automatic t_fast();
    dbl = 1'b0; cfg(1, 5, 5, 0); idle(1);
    chk("R5", "fast without doubler", err, 1);
    dbl = 1'b1; idle(1);
    chk("R5", "fast with doubler", err, 0);
    dbl = 1'b0; cfg(0, 5, 5, 0); idle(1);
    chk("R5", "basic without doubler", err, 0);
  endtask

  task automatic t_freq();
    dbl = 1'b1; cfg(0, 0, 5, 0); idle(1);
    chk("R6", "100MHz div1 over limit", err, 1);
    cfg(0, 2, 5, 0); idle(1);
    chk("R6", "100MHz div1.5 ok", err, 0);
    dbl = 1'b0; cfg(0, 0, 5, 0); idle(1);
    chk("R6", "50MHz div1 ok", err, 0);
  endtask

  task automatic t_send();
    int hi, per;
    int tps[3] = '{0, 3, 7};
    foreach (tps[k]) begin
      act = 1'b0; cfg(0, 0, 0, tps[k]); idle(3);
      act = 1'b1;
      meas_stb(hi, per);
      chk("R7", $sformatf("stb high tp=%0d", tps[k]), hi, (tps[k] + 4) / 2);
      chk("R7", $sformatf("stb period tp=%0d", tps[k]), per, tps[k] + 4);
    end
    act = 1'b0; cfg(0, 5, 0, 1); idle(12);
    act = 1'b1;
    meas_stb(hi, per);
    chk("R7", "stb high div4 tp=1", hi, 8);
    chk("R7", "stb period div4 tp=1", per, 20);
    act = 1'b0;
  endtask

  task automatic t_gate();
    int cnt = 0;
    cfg(0, 0, 0, 0); act = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(stb); end
    chk("R8", "stb while idle", cnt, 0);
    act = 1'b1; idle(10);
    act = 1'b0; @(negedge clk);
    chk("R8", "stb right after drop", stb, 0);
  endtask

  task automatic t_rx();
    int g, s;
    cfg(0, 0, 0, 0); idle(4);
    g = 0; do begin @(negedge clk); g++; end while (!rxt && g < 100);
    chk("R9", "sce with rx", sce, 1);
    g = 0; do begin @(negedge clk); g++; end while (!rxt && g < 100);
    chk("R9", "rx gap div1", g, 4);
    cfg(0, 3, 0, 0); idle(12);
    g = 0; do begin @(negedge clk); g++; end while (!rxt && g < 100);
    g = 0; s = 0;
    do begin @(negedge clk); g++; s += int'(sce); end while (!rxt && g < 100);
    chk("R9", "rx gap div2", g, 8);
    chk("R9", "sce per rx", s, 4);
  endtask

  task automatic t_boundary();
    int g1, g2, hi, per;
    cfg(0, 5, 0, 0); idle(12);
    next_sce(g1);
    @(negedge clk);
    cfg(0, 3, 0, 0);
    next_sce(g1);
    next_sce(g2);
    chk("R10", "old gap finishes", g1 + 1, 4);
    chk("R10", "new gap after boundary", g2, 2);
    act = 1'b0; cfg(0, 0, 0, 0); idle(3);
    act = 1'b1;
    g1 = 0;
    do begin @(negedge clk); g1++; end while (stb && g1 < 100);
    do begin @(negedge clk); g1++; end while (!stb && g1 < 100);
    cfg(0, 0, 0, 4);
    from_rise(hi, per);
    chk("R10", "current period high kept", hi, 2);
    chk("R10", "current period kept", per, 4);
    from_rise(hi, per);
    chk("R10", "next period high", hi, 4);
    chk("R10", "next period", per, 8);
    act = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sync_div();
    t_async_div();
    t_reserved();
    t_fast();
    t_freq();
    t_send();
    t_gate();
    t_rx();
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule